// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Command Decoder

This block sits between a processor whose low address byte shares pins with its 8-bit data bus and a memory and I/O system. It captures the low address byte from the shared bus whenever the address-latch strobe is high. It joins that byte with the dedicated upper address lines to present a stable 20-bit address for the rest of the bus cycle.

The block also turns the active-low read and write strobes into four separate active-low commands: memory read, memory write, I/O read and I/O write. The memory/I-O select picks between the memory pair and the I/O pair. A select value of 1 means I/O and 0 means memory.

The block drives the enable and direction of the bidirectional data buffer. The buffer drives only during the data phase of a single, valid access. If read and write are both active at once, the block suppresses every command and raises an error flag. All outputs are registered and change on the rising clock edge that follows the inputs that cause them.

Top module: `bus_demux_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the four commands are high, the buffer enable is high (disabled), the buffer direction is 0, the error flag is 0 and the address is 0.
- R2: If the latch strobe is 1 at a rising edge, the address output after that edge is {upper lines, shared-bus byte}. The upper lines form bits 19..8 and the shared-bus byte forms bits 7..0.
- R3: If the latch strobe is 0 at a rising edge, the address output keeps its value, whatever the shared bus and the upper lines carry.
- R4: After an edge, each command reflects the inputs sampled at that edge. Memory read is low when read is 0, write is 1 and select is 0. Memory write is low when write is 0, read is 1 and select is 0. I/O read is low when read is 0, write is 1 and select is 1. I/O write is low when write is 0, read is 1 and select is 1. In every other case the command is high.
- R5: At most one of the four commands is low in any cycle.
- R6: If read and write are both 0 at an edge, all four commands are high and the error flag is 1 after that edge. Otherwise the error flag is 0.
- R7: The buffer enable is low after an edge only if exactly one of read and write was 0 and the latch strobe was 0 at that edge. A latch strobe of 1 keeps the buffer disabled.
- R8: The buffer direction output equals the transmit pin sampled at the previous edge. A value of 1 means the processor drives data out and 0 means data flows toward the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| latchStb | input | 1 | Address-latch strobe, high while the shared byte carries address |
| sharedBus | input | 8 | Shared address/data low byte |
| upperAddr | input | 12 | Dedicated address lines 19..8 |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| ioSel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| txDir | input | 1 | 1 = processor transmits, 0 = processor receives |
| addrOut | output | 20 | Demultiplexed address |
| memRdN | output | 1 | Memory read command, active low |
| memWrN | output | 1 | Memory write command, active low |
| ioRdN | output | 1 | I/O read command, active low |
| ioWrN | output | 1 | I/O write command, active low |
| bufEnN | output | 1 | Data buffer enable, active low |
| bufDir | output | 1 | Data buffer direction |
| rwConflict | output | 1 | Read and write were active together |

## Verification
Address capture and command decode can fall in the same cycle. This happens when the latch strobe is still high while a read or write strobe is already low. The bench provokes this by driving both together and by changing the shared byte and the strobes on the next cycle. The bench judges that the new address is captured, that the command still issues, and that the buffer stays disabled until the strobe falls. It then checks that the address holds while the shared bus toggles through the data phase.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;
  typedef struct packed {
    logic latchEn;
    logic memRd;
    logic memWr;
    logic ioRd;
    logic ioWr;
    logic bufEn;
    logic bufTx;
    logic conflict;
  } ctrlStrobes_t;
endpackage

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import bus_demux_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         latchStb,
  input  logic         rdN,
  input  logic         wrN,
  input  logic         ioSel,
  input  logic         txDir,
  output ctrlStrobes_t strobes
);
  localparam int NUM_CMD = 4;

  logic rdAct, wrAct, conflictNext, singleAct;
  logic [NUM_CMD-1:0] cmdNext;
  logic [NUM_CMD-1:0] cmdQ;
  logic bufEnQ, bufTxQ, conflictQ;

  assign rdAct        = ~rdN;
  assign wrAct        = ~wrN;
  assign conflictNext = rdAct & wrAct;
  assign singleAct    = rdAct ^ wrAct;

  // index bit 1: write (1) / read (0); index bit 0: I/O (1) / memory (0)
  for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
    localparam bit IS_WR = (i / 2) == 1;
    localparam bit IS_IO = (i % 2) == 1;
    always_comb begin
      cmdNext[i] = singleAct & (IS_WR ? wrAct : rdAct) & (ioSel == IS_IO);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ      <= '0;
      bufEnQ    <= 1'b0;
      bufTxQ    <= 1'b0;
      conflictQ <= 1'b0;
    end else begin
      cmdQ      <= cmdNext;
      bufEnQ    <= singleAct & ~latchStb;
      bufTxQ    <= txDir;
      conflictQ <= conflictNext;
    end
  end

  always_comb begin
    strobes.latchEn  = latchStb;
    strobes.memRd    = cmdQ[0];
    strobes.ioRd     = cmdQ[1];
    strobes.memWr    = cmdQ[2];
    strobes.ioWr     = cmdQ[3];
    strobes.bufEn    = bufEnQ;
    strobes.bufTx    = bufTxQ;
    strobes.conflict = conflictQ;
  end
endmodule

// File: rtl/addr_path.sv
module addr_path #(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 12,
  localparam int ADDR_W = LOW_W + HIGH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchEn,
  input  logic [LOW_W-1:0]  lowIn,
  input  logic [HIGH_W-1:0] highIn,
  output logic [ADDR_W-1:0] addrQ
);
  always_ff @(posedge clk) begin
    if (!rstN)        addrQ <= '0;
    else if (latchEn) addrQ <= {highIn, lowIn};
  end
endmodule

// File: rtl/bus_demux_top.sv
module bus_demux_top
  import bus_demux_pkg::*;
#(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 12,
  localparam int ADDR_W = LOW_W + HIGH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchStb,
  input  logic [LOW_W-1:0]  sharedBus,
  input  logic [HIGH_W-1:0] upperAddr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              ioSel,
  input  logic              txDir,
  output logic [ADDR_W-1:0] addrOut,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              bufEnN,
  output logic              bufDir,
  output logic              rwConflict
);
  ctrlStrobes_t strobes;

  bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .rdN(rdN), .wrN(wrN),
    .ioSel(ioSel), .txDir(txDir), .strobes(strobes)
  );

  addr_path #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_addr (
    .clk(clk), .rstN(rstN), .latchEn(strobes.latchEn),
    .lowIn(sharedBus), .highIn(upperAddr), .addrQ(addrOut)
  );

  assign memRdN     = ~strobes.memRd;
  assign memWrN     = ~strobes.memWr;
  assign ioRdN      = ~strobes.ioRd;
  assign ioWrN      = ~strobes.ioWr;
  assign bufEnN     = ~strobes.bufEn;
  assign bufDir     = strobes.bufTx;
  assign rwConflict = strobes.conflict;
endmodule

// File: rtl/bus_demux_checker.sv
module bus_demux_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              latchStb,
  input logic              rdN,
  input logic              wrN,
  input logic              ioSel,
  input logic [ADDR_W-1:0] addrOut,
  input logic              memRdN,
  input logic              memWrN,
  input logic              ioRdN,
  input logic              ioWrN,
  input logic              bufEnN,
  input logic              rwConflict
);
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !latchStb |=> $stable(addrOut));

  a_r5_one_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~memRdN, ~memWrN, ~ioRdN, ~ioWrN}));

  a_r6_conflict: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |=> (rwConflict && memRdN && memWrN && ioRdN && ioWrN));

  a_r7_no_drive_in_addr: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |=> bufEnN);

  a_r4_mem_read: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && wrN && !ioSel) |=> !memRdN);

  a_r4_io_write: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && rdN && ioSel) |=> !ioWrN);
endmodule

bind bus_demux_top bus_demux_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .latchStb(latchStb), .rdN(rdN), .wrN(wrN),
  .ioSel(ioSel), .addrOut(addrOut), .memRdN(memRdN), .memWrN(memWrN),
  .ioRdN(ioRdN), .ioWrN(ioWrN), .bufEnN(bufEnN), .rwConflict(rwConflict)
);

// File: tb/sim_bus_demux_top.sv
module sim_bus_demux_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchStb = 1'b0;
  logic [7:0] sharedBus = '0;
  logic [11:0] upperAddr = '0;
  logic rdN = 1'b1, wrN = 1'b1, ioSel = 1'b0, txDir = 1'b0;
  logic [19:0] addrOut;
  logic memRdN, memWrN, ioRdN, ioWrN, bufEnN, bufDir, rwConflict;

  int vecCount = 0;
  int errCount = 0;
  bit done = 1'b0;

  typedef struct {
    logic [19:0] addr;
    logic [3:0]  cmdN;   // {memRdN, memWrN, ioRdN, ioWrN}
    logic        enN;
    logic        dir;
    logic        err;
  } expItem_t;

  expItem_t expQ[$];
  logic [19:0] modelAddr = '0;

  always #4 clk = ~clk;

  bus_demux_top u0 (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .sharedBus(sharedBus),
    .upperAddr(upperAddr), .rdN(rdN), .wrN(wrN), .ioSel(ioSel), .txDir(txDir),
    .addrOut(addrOut), .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN),
    .ioWrN(ioWrN), .bufEnN(bufEnN), .bufDir(bufDir), .rwConflict(rwConflict)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and predict the result
  task automatic drive(logic ale, logic [7:0] bus, logic [11:0] hi,
                       logic r, logic w, logic sel, logic tx);
    expItem_t e;
    bit rA, wA, single;
    @(negedge clk);
    latchStb = ale; sharedBus = bus; upperAddr = hi;
    rdN = r; wrN = w; ioSel = sel; txDir = tx;
    rA = !r; wA = !w; single = rA ^ wA;
    if (ale) modelAddr = {hi, bus};
    e.addr = modelAddr;
    e.cmdN = {!(single && rA && !sel), !(single && wA && !sel),
              !(single && rA && sel), !(single && wA && sel)};
    e.enN  = !(single && !ale);
    e.dir  = tx;
    e.err  = rA && wA;
    expQ.push_back(e);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check("R2/R3 addr", 32'(addrOut), 32'(e.addr));
        check("R4 commands", 32'({memRdN, memWrN, ioRdN, ioWrN}), 32'(e.cmdN));
        check("R5 onehot", 32'($countones(~{memRdN, memWrN, ioRdN, ioWrN}) <= 1), 32'd1);
        check("R7 bufEnN", 32'(bufEnN), 32'(e.enN));
        check("R8 bufDir", 32'(bufDir), 32'(e.dir));
        check("R6 conflict", 32'(rwConflict), 32'(e.err));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      vecCount++; errCount++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 addr", 32'(addrOut), 32'd0);
    check("R1 commands", 32'({memRdN, memWrN, ioRdN, ioWrN}), 32'hF);
    check("R1 bufEnN", 32'(bufEnN), 32'd1);
    check("R1 bufDir", 32'(bufDir), 32'd0);
    check("R1 conflict", 32'(rwConflict), 32'd0);
    rstN = 1'b1;

    // memory read cycle: address phase, then data phase with bus toggling (R2, R3, R4)
    drive(1, 8'h34, 12'hFE0, 1, 1, 0, 0);
    drive(0, 8'hAA, 12'h123, 0, 1, 0, 0);
    drive(0, 8'h55, 12'h456, 0, 1, 0, 0);
    drive(0, 8'h00, 12'h000, 1, 1, 0, 0);
    // memory write
    drive(1, 8'h01, 12'h000, 1, 1, 0, 1);
    drive(0, 8'hC3, 12'hFFF, 1, 0, 0, 1);
    // I/O read
    drive(1, 8'h60, 12'h000, 1, 1, 1, 0);
    drive(0, 8'h99, 12'h000, 0, 1, 1, 0);
    // I/O write
    drive(1, 8'h80, 12'h00F, 1, 1, 1, 1);
    drive(0, 8'h7E, 12'h00F, 1, 0, 1, 1);
    // overlap: latch strobe high while read active (R2 and R7 together)
    drive(1, 8'hF0, 12'hABC, 0, 1, 0, 0);
    drive(1, 8'h0F, 12'hCBA, 0, 1, 0, 0);
    drive(0, 8'h11, 12'h111, 0, 1, 0, 0);
    // R6 conflict with memory and I/O select
    drive(0, 8'h22, 12'h222, 0, 0, 0, 1);
    drive(0, 8'h22, 12'h222, 0, 0, 1, 0);
    drive(0, 8'h22, 12'h222, 1, 1, 1, 0);
    // sweep all strobe combinations
    for (int i = 0; i < 64; i++) begin
      drive(i[0], 8'(i * 37), 12'(i * 291), i[1], i[2], i[3], i[4]);
    end
    drive(0, 8'h00, 12'h000, 1, 1, 0, 0);
    repeat (3) @(negedge clk);

    // reset again mid-run (R1)
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset addr", 32'(addrOut), 32'd0);
    check("R1 re-reset bufEnN", 32'(bufEnN), 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule